// File: doc/BRIEF.md
# NMI Source Arbiter with Programmable Fetch Trap

This block drives a peripheral's non-maskable interrupt and keeps track of whether the NMI in progress belongs to the peripheral. Two sources can start one: a push button, which is synchronised and debounced here, and a comparator that watches every instruction fetch against a trap address held in software-writable registers. Both sources share one path. The path sets an "owned" flag and drives a fixed-length NMI pulse. A fetch of the interrupt vector is flagged for page-in only when the flag is set. An NMI started by another device on the shared line does not set the flag, so its vector fetch passes through without a page-in.

The owned flag stays set until the CPU fetches the two-byte return-from-NMI instruction (opcode 0xED immediately followed by opcode 0x45). While the flag is set, the handler may page out or call host ROM code, and further button presses or trap hits start no new NMI. Software loads the trap address one byte at a time through a data port. It controls the trap through a control port, whose readback shows the trap-enable bit, so software can update that bit with a read-modify-write.

Top module: `nmiArbiter`

## Requirements
- R1: After reset, nmiOut, nmiOwned, vectorPageIn and ctrlRead are all 0, the trap is disarmed and the next trap-port write targets the low byte.
- R2: When buttonIn has been high and stable for DEBOUNCE_CYCLES clocks, nmiOwned is set and nmiOut is high for exactly PULSE_CYCLES consecutive cycles. A high glitch shorter than DEBOUNCE_CYCLES starts no NMI.
- R3: A fetch from VECTOR_ADDR (default 0x0066) while nmiOwned is 1 raises vectorPageIn for exactly one cycle, in the cycle after the fetch.
- R4: A fetch from VECTOR_ADDR while nmiOwned is 0, which is the case for an NMI raised by a downstream device, leaves vectorPageIn at 0.
- R5: nmiOwned is cleared only by a fetch of opcode 0x45 that directly follows a fetch of opcode 0xED. If any other fetch falls between the two, the flag stays set.
- R6: While nmiOwned is 1, neither a debounced button press nor a trap hit produces an nmiOut pulse.
- R7: Successive writes to TRAP_PORT (default 0x023B) load the trap address low byte first, then the high byte, and the byte pointer alternates after each write.
- R8: Any write to CTRL_PORT (default 0x033B) returns the trap byte pointer to the low byte.
- R9: Bit 3 of a CTRL_PORT write arms the trap. While the trap is armed and nmiOwned is 0, a fetch whose address equals the trap address sets nmiOwned and pulses nmiOut exactly as a button press does, and it does not raise vectorPageIn by itself. While the trap is disarmed, a matching fetch has no effect.
- R10: ctrlRead bit 3 shows the trap-enable bit, and all other ctrlRead bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| buttonIn | input | 1 | Raw NMI button level, high when pressed |
| fetchValid | input | 1 | One-cycle strobe marking an opcode fetch |
| fetchAddr | input | ADDR_W | Address of the opcode fetch |
| fetchData | input | 8 | Opcode byte fetched |
| ioWrite | input | 1 | One-cycle strobe marking an I/O write |
| ioAddr | input | 16 | I/O write port address |
| ioWData | input | 8 | I/O write data |
| ctrlRead | output | 8 | Control register readback (bit 3 = trap enable) |
| nmiOut | output | 1 | NMI request pulse, high to drive the NMI line active |
| nmiOwned | output | 1 | Set while a self-raised NMI is being serviced |
| vectorPageIn | output | 1 | One-cycle page-in request for an owned vector fetch |

## Verification
The bench builds the block with DEBOUNCE_CYCLES = 4 and PULSE_CYCLES = 4. With these values, a full debounced press, the complete NMI pulse and a sub-threshold glitch each fit in a few dozen cycles, and the bench can count the pulse length exactly. The default 16-bit address width and the default port and vector values are kept, so the low-byte-first loading order, the pointer reset and the 0x0066 page-in decision are tested on the same encodings that software uses.

// File: rtl/nmiArbiterPkg.sv
package nmiArbiterPkg;

  localparam logic [7:0] OP_PREFIX_ED = 8'hED;
  localparam logic [7:0] OP_RETN_TAIL = 8'h45;
  localparam int         CTRL_TRAP_BIT = 3;

  typedef struct packed {
    logic wrTrapByte;
    logic wrCtrl;
  } dpStrobes_t;

endpackage

// File: rtl/nmiArbiterData.sv
module nmiArbiterData
  import nmiArbiterPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [7:0]        wrData,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              trapHit,
  output logic              trapEn
);

  localparam int NUM_BYTES = ADDR_W / 8;
  localparam int PTR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [ADDR_W-1:0] trapAddr;
  logic [PTR_W-1:0]  bytePtr;

  // one register lane per address byte, selected by the byte pointer
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trapAddr[i*8 +: 8] <= '0;
      end else if (strobes.wrTrapByte && bytePtr == PTR_W'(i)) begin
        trapAddr[i*8 +: 8] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytePtr <= '0;
      trapEn  <= 1'b0;
    end else if (strobes.wrCtrl) begin
      bytePtr <= '0;
      trapEn  <= wrData[CTRL_TRAP_BIT];
    end else if (strobes.wrTrapByte) begin
      if (bytePtr == PTR_W'(NUM_BYTES - 1)) bytePtr <= '0;
      else                                   bytePtr <= bytePtr + 1'b1;
    end
  end

  assign trapHit = trapEn && fetchValid && (fetchAddr == trapAddr);

endmodule

// File: rtl/nmiArbiterCtrl.sv
module nmiArbiterCtrl
  import nmiArbiterPkg::*;
#(
  parameter int          ADDR_W          = 16,
  parameter int          DEBOUNCE_CYCLES = 16,
  parameter int          PULSE_CYCLES    = 8,
  parameter logic [15:0] TRAP_PORT       = 16'h023B,
  parameter logic [15:0] CTRL_PORT       = 16'h033B,
  parameter logic [15:0] VECTOR_ADDR     = 16'h0066
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              buttonIn,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [7:0]        fetchData,
  input  logic              ioWrite,
  input  logic [15:0]       ioAddr,
  input  logic              trapHit,
  output dpStrobes_t        strobes,
  output logic              nmiOut,
  output logic              nmiOwned,
  output logic              vectorPageIn
);

  localparam int DB_W    = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);

  // I/O decode into datapath strobes
  always_comb begin
    strobes.wrTrapByte = ioWrite && (ioAddr == TRAP_PORT);
    strobes.wrCtrl     = ioWrite && (ioAddr == CTRL_PORT);
  end

  // button synchroniser and debouncer
  logic [1:0]      btnSync;
  logic            btnStable;
  logic [DB_W-1:0] dbCount;
  logic            pressEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnSync   <= '0;
      btnStable <= 1'b0;
      dbCount   <= '0;
      pressEvt  <= 1'b0;
    end else begin
      btnSync  <= {btnSync[0], buttonIn};
      pressEvt <= 1'b0;
      if (btnSync[1] != btnStable) begin
        if (dbCount == DB_W'(DEBOUNCE_CYCLES - 1)) begin
          dbCount   <= '0;
          btnStable <= btnSync[1];
          pressEvt  <= btnSync[1];
        end else begin
          dbCount <= dbCount + 1'b1;
        end
      end else begin
        dbCount <= '0;
      end
    end
  end

  // return-from-NMI decode: prefix fetch directly followed by tail fetch
  logic edSeen;
  logic retnHit;

  assign retnHit = fetchValid && edSeen && (fetchData == OP_RETN_TAIL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           edSeen <= 1'b0;
    else if (fetchValid) edSeen <= (fetchData == OP_PREFIX_ED);
  end

  // shared raise path, ownership flag and pulse timer
  logic               raiseReq;
  logic [PULSE_W-1:0] pulseCount;
  logic               vectorFetch;

  assign raiseReq    = (pressEvt || trapHit) && !nmiOwned;
  assign vectorFetch = fetchValid && (fetchAddr == ADDR_W'(VECTOR_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiOwned     <= 1'b0;
      pulseCount   <= '0;
      vectorPageIn <= 1'b0;
    end else begin
      vectorPageIn <= vectorFetch && nmiOwned;
      if (retnHit) begin
        nmiOwned <= 1'b0;
      end else if (raiseReq) begin
        nmiOwned <= 1'b1;
      end
      if (raiseReq && !retnHit) begin
        pulseCount <= PULSE_W'(PULSE_CYCLES);
      end else if (pulseCount != '0) begin
        pulseCount <= pulseCount - 1'b1;
      end
    end
  end

  assign nmiOut = (pulseCount != '0);

endmodule

// File: rtl/nmiArbiter.sv
module nmiArbiter
  import nmiArbiterPkg::*;
#(
  parameter int          ADDR_W          = 16,
  parameter int          DEBOUNCE_CYCLES = 16,
  parameter int          PULSE_CYCLES    = 8,
  parameter logic [15:0] TRAP_PORT       = 16'h023B,
  parameter logic [15:0] CTRL_PORT       = 16'h033B,
  parameter logic [15:0] VECTOR_ADDR     = 16'h0066
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              buttonIn,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [7:0]        fetchData,
  input  logic              ioWrite,
  input  logic [15:0]       ioAddr,
  input  logic [7:0]        ioWData,
  output logic [7:0]        ctrlRead,
  output logic              nmiOut,
  output logic              nmiOwned,
  output logic              vectorPageIn
);

  dpStrobes_t strobes;
  logic       trapHit;
  logic       trapEn;

  nmiArbiterCtrl #(
    .ADDR_W(ADDR_W), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES), .PULSE_CYCLES(PULSE_CYCLES),
    .TRAP_PORT(TRAP_PORT), .CTRL_PORT(CTRL_PORT), .VECTOR_ADDR(VECTOR_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .buttonIn(buttonIn),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchData(fetchData),
    .ioWrite(ioWrite), .ioAddr(ioAddr), .trapHit(trapHit),
    .strobes(strobes), .nmiOut(nmiOut), .nmiOwned(nmiOwned),
    .vectorPageIn(vectorPageIn)
  );

  nmiArbiterData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(ioWData),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .trapHit(trapHit), .trapEn(trapEn)
  );

  always_comb begin
    ctrlRead = '0;
    ctrlRead[CTRL_TRAP_BIT] = trapEn;
  end

endmodule

// File: rtl/nmiArbiterChecker.sv
module nmiArbiterChecker (
  input logic       clk,
  input logic       rstN,
  input logic       fetchValid,
  input logic [7:0] fetchData,
  input logic [7:0] ctrlRead,
  input logic       nmiOut,
  input logic       nmiOwned,
  input logic       vectorPageIn
);

  // R6: a new pulse only starts when no owned NMI was in progress
  a_r6_no_pulse_while_owned: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiOut) |-> !$past(nmiOwned));

  // R2: every pulse goes with ownership
  a_r2_pulse_sets_owned: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiOut) |-> nmiOwned);

  // R3 / R4: page-in only follows an owned state
  a_r4_pagein_needs_owned: assert property (@(posedge clk) disable iff (!rstN)
    vectorPageIn |-> $past(nmiOwned));

  // R3: page-in request lasts a single cycle per fetch
  a_r3_pagein_single: assert property (@(posedge clk) disable iff (!rstN)
    vectorPageIn |=> !vectorPageIn || $past(fetchValid));

  // R5: ownership ends only on the tail opcode of the return instruction
  a_r5_clear_on_retn: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiOwned) |-> ($past(fetchValid) && $past(fetchData) == 8'h45));

  // R10: readback carries nothing but the enable bit
  a_r10_ctrl_mask: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRead & 8'hF7) == 8'h00);

endmodule

bind nmiArbiter nmiArbiterChecker u_checker (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchData(fetchData),
  .ctrlRead(ctrlRead), .nmiOut(nmiOut), .nmiOwned(nmiOwned),
  .vectorPageIn(vectorPageIn)
);

// File: tb/tb_nmiArbiter.sv
module tb_nmiArbiter;

  localparam int CLK_PERIOD = 10;
  localparam int DEB        = 4;
  localparam int PULSE      = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        buttonIn = 1'b0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic [7:0]  fetchData = '0;
  logic        ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWData = '0;
  logic [7:0]  ctrlRead;
  logic        nmiOut, nmiOwned, vectorPageIn;

  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmiArbiter #(.DEBOUNCE_CYCLES(DEB), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rstN(rstN), .buttonIn(buttonIn),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchData(fetchData),
    .ioWrite(ioWrite), .ioAddr(ioAddr), .ioWData(ioWData),
    .ctrlRead(ctrlRead), .nmiOut(nmiOut), .nmiOwned(nmiOwned),
    .vectorPageIn(vectorPageIn)
  );

  task automatic check(input string req, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic doFetch(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a; fetchData = d;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic ioWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWrite = 1'b1; ioAddr = a; ioWData = d;
    @(negedge clk);
    ioWrite = 1'b0;
  endtask

  task automatic countPulse(output int n);
    n = 0;
    for (int i = 0; i < PULSE + 4; i++) begin
      if (nmiOut) n++;
      @(negedge clk);
    end
  endtask

  task automatic doRetn();
    doFetch(16'h2000, 8'hED);
    doFetch(16'h2001, 8'h45);
  endtask

  task automatic testReset();
    check("R1 nmiOut", nmiOut, 0);
    check("R1 nmiOwned", nmiOwned, 0);
    check("R1 vectorPageIn", vectorPageIn, 0);
    check("R1 ctrlRead", ctrlRead, 0);
  endtask

  task automatic testForeignVector();
    doFetch(16'h0066, 8'hF5);
    check("R4 foreign vector no page-in", vectorPageIn, 0);
  endtask

  task automatic testGlitch();
    @(negedge clk); buttonIn = 1'b1;
    repeat (DEB - 2) @(negedge clk);
    buttonIn = 1'b0;
    repeat (20) @(negedge clk);
    check("R2 glitch ignored", nmiOwned, 0);
  endtask

  task automatic testButton();
    int n = 0;
    @(negedge clk); buttonIn = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (nmiOut) n++;
    end
    check("R2 owned after press", nmiOwned, 1);
    check("R2 pulse length", n, PULSE);
    buttonIn = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic testVectorOwned();
    doFetch(16'h0066, 8'hF5);
    check("R3 page-in on owned vector", vectorPageIn, 1);
    @(negedge clk);
    check("R3 page-in one cycle", vectorPageIn, 0);
  endtask

  task automatic testRetrigger();
    int n = 0;
    @(negedge clk); buttonIn = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (nmiOut) n++;
    end
    buttonIn = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 no pulse while owned", n, 0);
  endtask

  task automatic testRetn();
    doFetch(16'h2000, 8'hED);
    doFetch(16'h2001, 8'h00);
    doFetch(16'h2002, 8'h45);
    check("R5 split sequence keeps owned", nmiOwned, 1);
    doRetn();
    check("R5 RETN clears owned", nmiOwned, 0);
  endtask

  task automatic testTrap();
    int n;
    ioWr(16'h023B, 8'h34);
    ioWr(16'h023B, 8'h12);
    doFetch(16'h1234, 8'h00);
    check("R9 disarmed trap ignored", nmiOwned, 0);
    ioWr(16'h033B, 8'h08);
    check("R10 readback enable", ctrlRead, 8'h08);
    doFetch(16'h1234, 8'h00);
    check("R9 trap sets owned", nmiOwned, 1);
    check("R7 low byte first / R9 no direct page-in", vectorPageIn, 0);
    countPulse(n);
    check("R9 trap pulse length", n, PULSE);
    doRetn();
    check("R5 clear after trap", nmiOwned, 0);
  endtask

  task automatic testPointerReset();
    ioWr(16'h023B, 8'h78);
    ioWr(16'h033B, 8'h08);
    ioWr(16'h023B, 8'h56);
    doFetch(16'h7834, 8'h00);
    check("R8 high byte not written", nmiOwned, 0);
    doFetch(16'h1256, 8'h00);
    check("R8 pointer back to low byte", nmiOwned, 1);
    doRetn();
    ioWr(16'h033B, 8'hF7);
    check("R10 enable cleared, others masked", ctrlRead, 0);
    doFetch(16'h1256, 8'h00);
    check("R9 disarmed after clear", nmiOwned, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testForeignVector();
    testGlitch();
    testButton();
    testVectorOwned();
    testRetrigger();
    testRetn();
    testForeignVector();
    testTrap();
    testPointerReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule